// File: doc/BRIEF.md
# Dual-Channel Console Interrupt Front End

This block is the register-facing front end of a two-channel console serial port. A CPU sees it as eight byte registers on a simple single-cycle request bus. For each channel there is a status register, a command register and a holding register. A write to the holding register hands a character to the transmitter. A read from it pops the oldest received character from a small per-channel receive queue. The two channels share one interrupt register: a read returns the pending-interrupt status and a write loads the interrupt mask.

Receive events set a channel's receive-pending bit when that bit is unmasked. Transmit-pending interrupts do not come from the serializer. A free-running tick input is divided by a parameter (two by default), and each divided pulse marks both transmit-pending bits when either transmit mask bit is enabled. The interrupt line is a registered level. A read of channel A's status register drops it, and it also drops once no unmasked pending bit remains. Read data and transmit or flush strobes are combinational in the cycle of the access. All register state changes at the clock edge that ends the access.

Top module: `uic_dual_console`

## Requirements
- R1: After reset the interrupt line is 0, the interrupt register (address 3) reads 0x00, the mask is 0x00, both receive queues are empty, and the tick divider count is 0.
- R2: Reading address 3 returns the pending bits, with channel A transmit at bit 0, channel A receive at bit 1, channel B transmit at bit 4 and channel B receive at bit 5. Writing address 3 loads the mask with the same layout and other bits ignored, and does not change the pending bits.
- R3: The status registers (address 0 for A, 4 for B) read bit 0 = receive queue not empty and bit 2 = 1 always, with all other bits 0.
- R4: A receive strobe on a channel always queues its character if there is room. It sets that channel's receive-pending bit and raises the interrupt line only when that channel's receive mask bit is 1.
- R5: Reading a holding register (address 2 for A, 6 for B) returns the oldest queued character, removes it, and clears that channel's receive-pending bit. With an empty queue it returns 0x00.
- R6: Writing a holding register drives that channel's transmit strobe high in the same cycle with the written byte on its data output, and clears that channel's transmit-pending bit.
- R7: Every TICK_DIV-th tick pulse (every second one by default) sets both transmit-pending bits and raises the interrupt line if either transmit mask bit is 1. Other ticks change nothing visible.
- R8: A read of channel A's status register lowers the interrupt line at the next edge. A read of channel B's status register does not.
- R9: The interrupt line falls as soon as no pending bit that is also masked in remains.
- R10: Writing a command register (address 1 for A, 5 for B) with bit 3 set pulses that channel's flush output in the same cycle. With bit 3 clear there is no flush.
- R11: Each receive queue holds FIFO_DEPTH characters. A character arriving while the queue is full and not being read is dropped.
- R12: Address 7 and the command registers read 0x00, and a write to address 7 changes no state.
- R13: When a set event and a clear event hit the same bit or the interrupt line in one cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle, 0 otherwise |
| rx_valid_a | input | 1 | Channel A received-character strobe |
| rx_data_a | input | 8 | Channel A received character |
| rx_valid_b | input | 1 | Channel B received-character strobe |
| rx_data_b | input | 8 | Channel B received character |
| tx_tick | input | 1 | Periodic tick for synthetic transmit interrupts |
| tx_valid_a | output | 1 | Channel A transmit strobe |
| tx_data_a | output | 8 | Channel A transmit character |
| tx_flush_a | output | 1 | Channel A transmit flush pulse |
| tx_valid_b | output | 1 | Channel B transmit strobe |
| tx_data_b | output | 8 | Channel B transmit character |
| tx_flush_b | output | 1 | Channel B transmit flush pulse |
| irq | output | 1 | Level interrupt output |

## Verification
The assertions assume a single access per cycle and a tick that is a one-cycle strobe. They also assume that a set event and a same-cycle mask write are not combined when the interrupt is expected to rise. The stimulus drives every input for exactly one cycle and changes it only a little after the clock edge. The deliberate collisions use only the combinations the requirements define: receive with holding read, and divided tick with status-A read. A behavioural model with per-channel queues predicts the pending bits, the interrupt line and every read value on each cycle.

// File: rtl/uic_pkg.sv
package uic_pkg;
  localparam int NCH    = 2;
  localparam int CHAR_W = 8;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  // per-channel register offsets inside a 4-address window
  localparam int OFF_STAT = 0;
  localparam int OFF_CMD  = 1;
  localparam int OFF_HOLD = 2;
  localparam logic [ADDR_W-1:0] ADDR_INT   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_SPARE = 3'd7;

  localparam int CMD_FLUSH_BIT = 3;
  localparam logic [REG_W-1:0] TX_ALL    = 8'h11;
  localparam logic [REG_W-1:0] ISR_VALID = 8'h33;

  function automatic logic [ADDR_W-1:0] chan_addr(input int ch, input int off);
    return ADDR_W'(4 * ch + off);
  endfunction

  function automatic logic [REG_W-1:0] rx_mask(input int ch);
    return REG_W'(8'h02 << (4 * ch));
  endfunction

  function automatic logic [REG_W-1:0] tx_mask(input int ch);
    return REG_W'(8'h01 << (4 * ch));
  endfunction

  function automatic logic [REG_W-1:0] status_byte(input logic not_empty);
    return {5'b0, 1'b1, 1'b0, not_empty};
  endfunction
endpackage

// File: rtl/uic_rx_fifo.sv
module uic_rx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         nonempty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;
  logic             full, do_pop, do_push;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign nonempty = (count != '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign do_pop   = pop & nonempty;
  assign do_push  = push & (~full | do_pop);
  assign dout     = nonempty ? mem[rd_ptr] : '0;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  // R11: occupancy never exceeds the depth
  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R11: a push into a full queue without a read leaves it unchanged
  p_full_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop |=> full && $stable(wr_ptr) && $stable(rd_ptr));
  // R5: reading an empty queue leaves it empty
  p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !nonempty && pop && !push |=> !nonempty);
endmodule

// File: rtl/uic_tick_div.sv
module uic_tick_div #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic fire
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign fire = tick && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (fire) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  // R7: without a tick the divider holds its count
  p_div_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/uic_irq_core.sv
module uic_irq_core
  import uic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   rx_evt,
  input  logic [NCH-1:0]   hold_rd,
  input  logic [NCH-1:0]   hold_wr,
  input  logic             fire,
  input  logic             mask_we,
  input  logic [REG_W-1:0] mask_wdata,
  input  logic             stat_a_rd,
  output logic [REG_W-1:0] isr,
  output logic             irq
);
  logic [REG_W-1:0] isr_q, isr_d, imr_q, imr_d;
  logic             irq_q, irq_d;
  logic [NCH-1:0]   rx_set;
  logic             tx_set, set_evt;

  for (genvar c = 0; c < NCH; c++) begin : g_rxset
    assign rx_set[c] = rx_evt[c] & |(imr_q & rx_mask(c));
  end
  assign tx_set  = fire & |(imr_q & TX_ALL);
  assign set_evt = |rx_set | tx_set;

  always_comb begin
    isr_d = isr_q;
    for (int c = 0; c < NCH; c++) begin
      if (hold_rd[c]) isr_d = isr_d & ~rx_mask(c);
      if (hold_wr[c]) isr_d = isr_d & ~tx_mask(c);
    end
    for (int c = 0; c < NCH; c++) begin
      if (rx_set[c]) isr_d = isr_d | rx_mask(c);
    end
    if (tx_set) isr_d = isr_d | TX_ALL;
    imr_d = mask_we ? (mask_wdata & ISR_VALID) : imr_q;
    irq_d = (set_evt | (irq_q & ~stat_a_rd)) & |(isr_d & imr_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      imr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      isr_q <= isr_d;
      imr_q <= imr_d;
      irq_q <= irq_d;
    end
  end

  assign isr = isr_q;
  assign irq = irq_q;

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R4: a masked-off receive event never creates a pending bit
    p_masked_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_evt[c] && !(|(imr_q & rx_mask(c))) && !(|(isr_q & rx_mask(c)))
      |=> !(|(isr_q & rx_mask(c))));
    // R5: holding read clears receive pending
    p_hold_rd_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hold_rd[c] && !rx_set[c] |=> !(|(isr_q & rx_mask(c))));
    // R6: holding write clears transmit pending
    p_hold_wr_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hold_wr[c] && !tx_set |=> !(|(isr_q & tx_mask(c))));
    // R13: a receive set beats a same-cycle holding read
    p_set_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
      rx_set[c] && hold_rd[c] |=> |(isr_q & rx_mask(c)));
  end

  // R7: a divided tick with a transmit mask marks both transmit bits
  p_tick_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_set && !mask_we |=> ((isr_q & TX_ALL) == TX_ALL) && irq_q);
  // R8: status-A read drops the line when nothing new arrives
  p_stat_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_a_rd && !set_evt |=> !irq_q);
  // R9: the line is only high while an enabled pending bit exists
  p_irq_backed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> |(isr_q & imr_q));
endmodule

// File: rtl/uic_dual_console.sv
module uic_dual_console
  import uic_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int TICK_DIV   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_req,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rx_valid_a,
  input  logic [7:0] rx_data_a,
  input  logic       rx_valid_b,
  input  logic [7:0] rx_data_b,
  input  logic       tx_tick,
  output logic       tx_valid_a,
  output logic [7:0] tx_data_a,
  output logic       tx_flush_a,
  output logic       tx_valid_b,
  output logic [7:0] tx_data_b,
  output logic       tx_flush_b,
  output logic       irq
);
  logic              rd_en, wr_en, stat_a_rd, mask_we, fire;
  logic [NCH-1:0]    rx_valid, hold_rd, hold_wr, cmd_wr, ne;
  logic [CHAR_W-1:0] rx_data [NCH];
  logic [CHAR_W-1:0] q_dout  [NCH];
  logic [REG_W-1:0]  isr;

  assign rd_en     = bus_req & ~bus_wr;
  assign wr_en     = bus_req & bus_wr;
  assign stat_a_rd = rd_en && (bus_addr == chan_addr(0, OFF_STAT));
  assign mask_we   = wr_en && (bus_addr == ADDR_INT);
  assign rx_valid  = {rx_valid_b, rx_valid_a};
  assign rx_data[0] = rx_data_a;
  assign rx_data[1] = rx_data_b;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign hold_rd[c] = rd_en && (bus_addr == chan_addr(c, OFF_HOLD));
    assign hold_wr[c] = wr_en && (bus_addr == chan_addr(c, OFF_HOLD));
    assign cmd_wr[c]  = wr_en && (bus_addr == chan_addr(c, OFF_CMD));

    uic_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(CHAR_W)) u_rxq (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (rx_valid[c]),
      .din      (rx_data[c]),
      .pop      (hold_rd[c]),
      .dout     (q_dout[c]),
      .nonempty (ne[c])
    );
  end

  uic_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tx_tick),
    .fire  (fire)
  );

  uic_irq_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_evt     (rx_valid),
    .hold_rd    (hold_rd),
    .hold_wr    (hold_wr),
    .fire       (fire),
    .mask_we    (mask_we),
    .mask_wdata (bus_wdata),
    .stat_a_rd  (stat_a_rd),
    .isr        (isr),
    .irq        (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (bus_addr == ADDR_INT) bus_rdata = isr;
      for (int c = 0; c < NCH; c++) begin
        if (bus_addr == chan_addr(c, OFF_STAT)) bus_rdata = status_byte(ne[c]);
        if (bus_addr == chan_addr(c, OFF_HOLD)) bus_rdata = q_dout[c];
      end
    end
  end

  assign tx_valid_a = hold_wr[0];
  assign tx_data_a  = bus_wdata;
  assign tx_flush_a = cmd_wr[0] & bus_wdata[CMD_FLUSH_BIT];
  assign tx_valid_b = hold_wr[1];
  assign tx_data_b  = bus_wdata;
  assign tx_flush_b = cmd_wr[1] & bus_wdata[CMD_FLUSH_BIT];

  // R10: flush strobes are only produced by command-register writes
  p_flush_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush_a | tx_flush_b) |-> (wr_en && bus_wdata[CMD_FLUSH_BIT]));
  // R12: the spare address never returns data
  p_spare_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_addr == ADDR_SPARE) |-> (bus_rdata == '0));
endmodule

// File: tb/uic_dual_console_tb_top.sv
module uic_dual_console_tb_top;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 0, bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic rx_valid_a = 0, rx_valid_b = 0, tx_tick = 0;
  logic [7:0] rx_data_a = 0, rx_data_b = 0;
  logic tx_valid_a, tx_flush_a, tx_valid_b, tx_flush_b, irq;
  logic [7:0] tx_data_a, tx_data_b;

  int n_chk = 0, n_fail = 0, cycles = 0;

  uic_dual_console #(.FIFO_DEPTH(DEPTH), .TICK_DIV(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid_a(rx_valid_a), .rx_data_a(rx_data_a),
    .rx_valid_b(rx_valid_b), .rx_data_b(rx_data_b), .tx_tick(tx_tick),
    .tx_valid_a(tx_valid_a), .tx_data_a(tx_data_a), .tx_flush_a(tx_flush_a),
    .tx_valid_b(tx_valid_b), .tx_data_b(tx_data_b), .tx_flush_b(tx_flush_b),
    .irq(irq));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0] qa[$], qb[$];
  int m_isr = 0, m_imr = 0, m_seq = 0;
  bit m_irq = 0;

  function automatic int exp_rdata();
    if (!bus_req || bus_wr) return 0;
    case (bus_addr)
      3'd0: return 4 | (qa.size() > 0);
      3'd2: return (qa.size() > 0) ? int'(qa[0]) : 0;
      3'd3: return m_isr;
      3'd4: return 4 | (qb.size() > 0);
      3'd6: return (qb.size() > 0) ? int'(qb[0]) : 0;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int isr_n, imr_n;
    bit set, rd, wr;
    if (!rst_n) begin
      qa.delete(); qb.delete();
      m_isr = 0; m_imr = 0; m_seq = 0; m_irq = 0;
    end else begin
      rd = bus_req && !bus_wr;
      wr = bus_req && bus_wr;
      isr_n = m_isr;
      set = 0;
      if (rd && bus_addr == 2) begin if (qa.size() > 0) void'(qa.pop_front()); isr_n &= ~8'h02; end
      if (rd && bus_addr == 6) begin if (qb.size() > 0) void'(qb.pop_front()); isr_n &= ~8'h20; end
      if (wr && bus_addr == 2) isr_n &= ~8'h01;
      if (wr && bus_addr == 6) isr_n &= ~8'h10;
      if (rx_valid_a) begin
        if (qa.size() < DEPTH) qa.push_back(rx_data_a);
        if (m_imr & 8'h02) begin isr_n |= 8'h02; set = 1; end
      end
      if (rx_valid_b) begin
        if (qb.size() < DEPTH) qb.push_back(rx_data_b);
        if (m_imr & 8'h20) begin isr_n |= 8'h20; set = 1; end
      end
      if (tx_tick) begin
        m_seq++;
        if (m_seq == 2) begin
          m_seq = 0;
          if (m_imr & 8'h11) begin isr_n |= 8'h11; set = 1; end
        end
      end
      imr_n = (wr && bus_addr == 3) ? (bus_wdata & 8'h33) : m_imr;
      m_irq = (set || (m_irq && !(rd && bus_addr == 0))) && ((isr_n & imr_n) != 0);
      m_isr = isr_n;
      m_imr = imr_n;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8/R9 irq vs model", irq, m_irq);
      chk("R2/R3/R5/R12 rdata vs model", bus_rdata, exp_rdata());
      chk("R6 tx_valid_a vs model", tx_valid_a, bus_req && bus_wr && bus_addr == 2);
      chk("R6 tx_valid_b vs model", tx_valid_b, bus_req && bus_wr && bus_addr == 6);
      if (tx_valid_a) chk("R6 tx_data_a", tx_data_a, bus_wdata);
      if (tx_valid_b) chk("R6 tx_data_b", tx_data_b, bus_wdata);
      chk("R10 flush_a vs model", tx_flush_a, bus_req && bus_wr && bus_addr == 1 && bus_wdata[3]);
      chk("R10 flush_b vs model", tx_flush_b, bus_req && bus_wr && bus_addr == 5 && bus_wdata[3]);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic release_all();
    @(posedge clk); #1;
    bus_req = 0; bus_wr = 0; rx_valid_a = 0; rx_valid_b = 0; tx_tick = 0;
  endtask

  task automatic rd(input logic [2:0] a, input int exp, input string tag);
    @(posedge clk); #1;
    bus_req = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
    release_all();
  endtask

  task automatic wr_begin(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_req = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_begin(a, d);
    release_all();
  endtask

  task automatic rx(input bit ch, input logic [7:0] d);
    @(posedge clk); #1;
    if (ch) begin rx_valid_b = 1; rx_data_b = d; end
    else    begin rx_valid_a = 1; rx_data_a = d; end
    release_all();
  endtask

  task automatic tick();
    @(posedge clk); #1;
    tx_tick = 1;
    release_all();
  endtask

  task automatic chk_irq(input bit exp, input string tag);
    @(negedge clk);
    chk(tag, irq, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk_irq(0, "R1 irq after reset");
    rd(3, 8'h00, "R1 int status after reset");
    rd(0, 8'h04, "R1 status A empty after reset");
    rd(4, 8'h04, "R3 status B empty");
    // R4 masked receive
    rx(0, 8'h41);
    rd(3, 8'h00, "R4 masked rx sets nothing");
    chk_irq(0, "R4 masked rx no irq");
    rd(0, 8'h05, "R3 status A data available");
    // R2/R4 unmasked receive
    wr(3, 8'h33);
    rx(0, 8'h42);
    chk_irq(1, "R4 unmasked rx raises irq");
    rd(3, 8'h02, "R2 int status read");
    rd(4, 8'h04, "R3 status B");
    chk_irq(1, "R8 status B read keeps irq");
    rd(0, 8'h05, "R3 status A");
    chk_irq(0, "R8 status A read drops irq");
    rd(3, 8'h02, "R2 pending kept after status read");
    // R5 holding reads
    rd(2, 8'h41, "R5 oldest char");
    rd(3, 8'h00, "R5 rx pending cleared");
    rd(2, 8'h42, "R5 second char");
    rd(2, 8'h00, "R5 empty read returns zero");
    rd(0, 8'h04, "R3 status A empty again");
    // R7 divided tick
    tick();
    rd(3, 8'h00, "R7 first tick no effect");
    chk_irq(0, "R7 first tick no irq");
    tick();
    chk_irq(1, "R7 second tick raises irq");
    rd(3, 8'h11, "R7 both tx bits set");
    // R6 holding writes
    wr_begin(2, 8'h55);
    chk("R6 tx strobe A", tx_valid_a, 1);
    chk("R6 tx data A", tx_data_a, 8'h55);
    release_all();
    rd(3, 8'h10, "R6 tx A bit cleared");
    wr(6, 8'h66);
    chk_irq(0, "R9 irq falls with no pending");
    // R9 via mask
    tick(); tick();
    chk_irq(1, "R7 irq again");
    wr(3, 8'h00);
    chk_irq(0, "R9 mask removal drops irq");
    rd(3, 8'h11, "R2 mask write keeps status");
    wr(2, 8'h01); wr(6, 8'h02);
    rd(3, 8'h00, "R6 both tx bits cleared");
    wr(3, 8'h33);
    // R10 flush
    wr_begin(1, 8'h08);
    chk("R10 flush A on bit3", tx_flush_a, 1);
    chk("R10 no flush B", tx_flush_b, 0);
    release_all();
    wr_begin(1, 8'h07);
    chk("R10 no flush without bit3", tx_flush_a, 0);
    release_all();
    wr_begin(5, 8'hFF);
    chk("R10 flush B", tx_flush_b, 1);
    release_all();
    // R11 overflow
    for (int i = 0; i < 6; i++) rx(1, 8'(8'h10 + i));
    rd(4, 8'h05, "R3 status B data available");
    for (int i = 0; i < DEPTH; i++) rd(6, 8'h10 + i, "R11 kept char");
    rd(6, 8'h00, "R11 overflow chars dropped");
    // R12 spare / command reads
    wr(7, 8'h00);
    rd(7, 8'h00, "R12 spare reads zero");
    rd(1, 8'h00, "R12 command A reads zero");
    rd(3, 8'h00, "R12 status untouched");
    rx(0, 8'h77);
    chk_irq(1, "R12 mask untouched by spare write");
    rd(2, 8'h77, "R5 char read");
    chk_irq(0, "R9 irq falls after read");
    // R13 same-cycle collisions
    @(posedge clk); #1;
    rx_valid_a = 1; rx_data_a = 8'h88; bus_req = 1; bus_wr = 0; bus_addr = 2;
    release_all();
    rd(3, 8'h02, "R13 rx set beats holding read");
    chk_irq(1, "R13 irq up");
    tick();
    @(posedge clk); #1;
    tx_tick = 1; bus_req = 1; bus_wr = 0; bus_addr = 0;
    release_all();
    chk_irq(1, "R13 tick set beats status A read");
    rd(3, 8'h13, "R13 pending after collision");
    repeat (4) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule